// File: doc/BRIEF.md
# Byte-Bus Loader for a 12-Bit DAC Input Register

This block lets a narrow 8-bit host bus drive a 12-bit parallel DAC code. The host first writes the top four code bits to a small holding latch at one decoded address. It then writes the bottom eight bits at a second decoded address. That second write moves the full 12-bit word into the DAC register in a single clock edge, so the converter never sees a code that is only half updated.

The DAC register copies the behaviour of a converter input stage with an active-low select and an active-low write strobe. It loads while both are low and otherwise holds its last value. The strobe comes only from the qualified write-enable cycle, so the register can change only while bus data is valid.

Two options are fixed at elaboration. With the two's-complement option, the DAC code bit 11 is inverted, which turns two's-complement input into offset binary. A 12-bit word of 0x000 then drives mid-scale (0x800), and 0x7FF drives full scale (0xFFF, that is 4095/4096 of the reference). With the address-window option, any write whose upper four address bits match a block number loads the lower 12 address bits straight into the DAC register.

Top module: `dac_byte_loader`

## Requirements
- R1: While rst_ni is low, dac_code_o is 0x000 (0x800 when TWOS_COMP=1), update_o is 0 and the held nibble is 0.
- R2: A write (wr_en_i=1) to LO_ADDR outside the block window sets dac_code_o to {held nibble, data_i[7:0]} at the next rising clock edge. Bit 11 is inverted when TWOS_COMP=1.
- R3: A write to NIB_ADDR stores data_i[3:0] as the held nibble and leaves dac_code_o unchanged.
- R4: dac_code_o changes only at an edge where update_o becomes 1. Writes to other addresses, and idle cycles, leave it unchanged.
- R5: update_o is 1 for exactly the one cycle after each clock edge that loads the DAC register, and 0 in every other cycle.
- R6: With TWOS_COMP=1, an assembled word of 0x000 gives 0x800 and a word of 0x7FF gives 0xFFF. With TWOS_COMP=0 the word passes through unchanged.
- R7: With ADDR_MAP_EN=1, a write whose address bits [15:12] equal BLOCK_BASE loads addr_i[11:0] (bit 11 inverted when TWOS_COMP=1). This load ignores data_i and the held nibble, and leaves the held nibble unchanged.
- R8: Address decode priority is, highest first: the block window, then LO_ADDR, then NIB_ADDR. A window hit on either byte address acts only as a window load.
- R9: Bus cycles with wr_en_i=0 have no effect, whatever the address and data.
- R10: The held nibble stays in place across any number of low-byte loads until the next write to NIB_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write qualifier; data is valid while high |
| addr_i | input | 16 | Host write address |
| data_i | input | 8 | Host write data |
| dac_code_o | output | 12 | Registered DAC input code |
| update_o | output | 1 | One-cycle pulse after each DAC register load |

## Verification
Several properties are checked on every cycle. The code holds steady whenever no update pulse follows. A write to the nibble address never moves the code. A low-byte write lands its data in bits 7:0. A window write lands its address bits in the code. The reset value is also checked on every cycle. Other behaviour depends on state built up over earlier writes, so only the bench's reference model can show it. This covers the full 12-bit word built from an earlier nibble, reuse of the nibble across many loads, the mid-scale and full-scale codes in offset mode, and decode priority when the window overlaps both byte addresses.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;

  typedef struct packed {
    logic blk;
    logic lo;
    logic nib;
  } dac_sel_t;

  function automatic logic [11:0] to_offset_bin(input logic [11:0] w, input bit en);
    to_offset_bin = en ? {~w[11], w[10:0]} : w;
  endfunction

endpackage

// File: rtl/dac_addr_decode.sv
module dac_addr_decode
  import dac_loader_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              CODE_W      = 12,
  parameter logic [ADDR_W-1:0] NIB_ADDR  = 'h0100,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 'h0101,
  parameter logic [ADDR_W-CODE_W-1:0] BLOCK_BASE = 'hC,
  parameter bit              ADDR_MAP_EN = 1'b1
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output dac_sel_t          sel_o
);
  localparam int BLK_W = ADDR_W - CODE_W;

  logic blk_hit;

  generate
    if (ADDR_MAP_EN) begin : g_window
      assign blk_hit = (addr_i[ADDR_W-1 -: BLK_W] == BLOCK_BASE);
    end else begin : g_no_window
      assign blk_hit = 1'b0;
    end
  endgenerate

  // priority: window > low byte > nibble
  always_comb begin
    sel_o     = '0;
    sel_o.blk = wr_en_i & blk_hit;
    sel_o.lo  = wr_en_i & ~blk_hit & (addr_i == LO_ADDR);
    sel_o.nib = wr_en_i & ~blk_hit & (addr_i != LO_ADDR) & (addr_i == NIB_ADDR);
  end

endmodule

// File: rtl/dac_nibble_latch.sv
module dac_nibble_latch #(
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NIB_W-1:0] d_i,
  output logic [NIB_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/dac_input_reg.sv
module dac_input_reg #(
  parameter int              CODE_W   = 12,
  parameter logic [CODE_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic [CODE_W-1:0] d_i,
  output logic [CODE_W-1:0] q_o,
  output logic              upd_o
);
  logic load;
  assign load = ~cs_ni & ~wr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= RST_VAL;
      upd_o <= 1'b0;
    end else begin
      upd_o <= load;
      if (load) q_o <= d_i;
    end
  end
endmodule

// File: rtl/dac_byte_loader.sv
module dac_byte_loader
  import dac_loader_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter int                CODE_W      = 12,
  parameter logic [ADDR_W-1:0] NIB_ADDR    = 'h0100,
  parameter logic [ADDR_W-1:0] LO_ADDR     = 'h0101,
  parameter logic [ADDR_W-CODE_W-1:0] BLOCK_BASE = 'hC,
  parameter bit                TWOS_COMP   = 1'b0,
  parameter bit                ADDR_MAP_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              update_o
);
  localparam int NIB_W = CODE_W - DATA_W;
  localparam logic [CODE_W-1:0] MSB_MASK = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] RST_CODE = TWOS_COMP ? MSB_MASK : '0;

  dac_sel_t          sel;
  logic [NIB_W-1:0]  nib_q;
  logic [CODE_W-1:0] word_raw;
  logic [CODE_W-1:0] word_dac;
  logic              cs_n;
  logic              wr_n;

  dac_addr_decode #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .NIB_ADDR(NIB_ADDR), .LO_ADDR(LO_ADDR),
    .BLOCK_BASE(BLOCK_BASE), .ADDR_MAP_EN(ADDR_MAP_EN)
  ) u_decode (
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  dac_nibble_latch #(.NIB_W(NIB_W)) u_nibble (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(sel.nib),
    .d_i   (data_i[NIB_W-1:0]),
    .q_o   (nib_q)
  );

  assign word_raw = sel.blk ? addr_i[CODE_W-1:0] : {nib_q, data_i};

  generate
    if (TWOS_COMP) begin : g_offset
      assign word_dac = word_raw ^ MSB_MASK;
    end else begin : g_straight
      assign word_dac = word_raw;
    end
  endgenerate

  // select/strobe only asserted in a qualified write cycle
  assign cs_n = ~(sel.lo | sel.blk);
  assign wr_n = ~wr_en_i;

  dac_input_reg #(.CODE_W(CODE_W), .RST_VAL(RST_CODE)) u_dac_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_ni (cs_n),
    .wr_ni (wr_n),
    .d_i   (word_dac),
    .q_o   (dac_code_o),
    .upd_o (update_o)
  );

endmodule

// File: rtl/dac_byte_loader_chk.sv
module dac_byte_loader_chk #(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter int                CODE_W      = 12,
  parameter logic [ADDR_W-1:0] NIB_ADDR    = 'h0100,
  parameter logic [ADDR_W-1:0] LO_ADDR     = 'h0101,
  parameter logic [ADDR_W-CODE_W-1:0] BLOCK_BASE = 'hC,
  parameter bit                TWOS_COMP   = 1'b0,
  parameter bit                ADDR_MAP_EN = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              update_o
);
  localparam int BLK_W = ADDR_W - CODE_W;
  localparam logic [CODE_W-1:0] FLIP = TWOS_COMP ? {1'b1, {(CODE_W-1){1'b0}}} : '0;

  logic in_win;
  assign in_win = ADDR_MAP_EN && (addr_i[ADDR_W-1 -: BLK_W] == BLOCK_BASE);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_STATE: assert (dac_code_o == FLIP && !update_o); // R1
    end
  end

  AST_LO_LOADS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !in_win && addr_i == LO_ADDR) |=>
      (update_o && dac_code_o[DATA_W-1:0] == $past(data_i))); // R2

  AST_NIB_KEEPS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !in_win && addr_i == NIB_ADDR && addr_i != LO_ADDR) |=>
      ($stable(dac_code_o) && !update_o)); // R3

  AST_HOLD_WITHOUT_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_o |-> $stable(dac_code_o)); // R4

  AST_IDLE_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !update_o); // R9

  AST_WINDOW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && in_win) |=>
      (update_o && dac_code_o == ($past(addr_i[CODE_W-1:0]) ^ FLIP))); // R7

endmodule

bind dac_byte_loader dac_byte_loader_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .NIB_ADDR(NIB_ADDR),
  .LO_ADDR(LO_ADDR), .BLOCK_BASE(BLOCK_BASE), .TWOS_COMP(TWOS_COMP),
  .ADDR_MAP_EN(ADDR_MAP_EN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .data_i(data_i), .dac_code_o(dac_code_o), .update_o(update_o)
);

// File: tb/dac_byte_loader_tb.sv
`timescale 1ns/1ps
module dac_byte_loader_tb;
  localparam int NDUT = 3;
  localparam int NIB_A = 'h0100;
  localparam int LO_A  = 'h0101;
  // dut0: straight code, dut1: offset binary, dut2: window overlaps both byte addresses
  localparam int TC[NDUT] = '{0, 1, 0};
  localparam int BB[NDUT] = '{12, 12, 0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [11:0] code_o [NDUT];
  logic        upd_o  [NDUT];

  int    m_code [NDUT];
  int    m_nib  [NDUT];
  int    m_upd  [NDUT];
  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  dac_byte_loader #(.TWOS_COMP(1'b0), .BLOCK_BASE(4'hC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .data_i(data),
    .dac_code_o(code_o[0]), .update_o(upd_o[0]));
  dac_byte_loader #(.TWOS_COMP(1'b1), .BLOCK_BASE(4'hC)) u_dut_tc (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .data_i(data),
    .dac_code_o(code_o[1]), .update_o(upd_o[1]));
  dac_byte_loader #(.TWOS_COMP(1'b0), .BLOCK_BASE(4'h0)) u_dut_pri (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .data_i(data),
    .dac_code_o(code_o[2]), .update_o(upd_o[2]));

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < NDUT; i++) begin
      int flip;
      flip = TC[i] ? 'h800 : 0;
      if (!rst_n) begin
        m_code[i] = flip; m_nib[i] = 0; m_upd[i] = 0;
      end else begin
        m_upd[i] = 0;
        if (wr_en) begin
          if ((int'(addr) >> 12) == BB[i]) begin
            m_code[i] = (int'(addr) & 'hFFF) ^ flip; m_upd[i] = 1;
          end else if (int'(addr) == LO_A) begin
            m_code[i] = ((m_nib[i] << 8) | int'(data)) ^ flip; m_upd[i] = 1;
          end else if (int'(addr) == NIB_A) begin
            m_nib[i] = int'(data) & 'hF;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      for (int i = 0; i < NDUT; i++) begin
        n_chk++;
        if (int'(code_o[i]) != m_code[i]) begin
          n_fail++;
          $display("FAIL %s dut%0d code act %h exp %h", cur_req, i, code_o[i], m_code[i]);
        end
        n_chk++;
        if (int'(upd_o[i]) != m_upd[i]) begin
          n_fail++;
          $display("FAIL %s dut%0d update act %0d exp %0d", cur_req, i, upd_o[i], m_upd[i]);
        end
      end
    end
  end

  task automatic bus(input bit we, input int a, input int d);
    @(negedge clk);
    #0.1;
    wr_en = we; addr = 16'(a); data = 8'(d);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) bus(1'b0, 0, 0);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    cur_req = "R1"; // reset values checked every cycle
    repeat (3) @(negedge clk);
    #0.5 rst_n = 1'b1;
    idle(1);
    cur_req = "R3";  bus(1, NIB_A, 'hA5); idle(2);       // nibble only, code holds
    cur_req = "R2";  bus(1, LO_A, 'h3C); idle(1);         // 0x53C / 0xD3C
    cur_req = "R9";  bus(0, LO_A, 'hFF); bus(0, NIB_A, 'h0F); idle(1);
    cur_req = "R4";  bus(1, 'h0200, 'h77); bus(1, 'h0102, 'h11); idle(1);
    cur_req = "R6";  bus(1, NIB_A, 'h00); bus(1, LO_A, 'h00); idle(1); // 0x000 -> 0x800
    cur_req = "R6";  bus(1, NIB_A, 'h07); bus(1, LO_A, 'hFF); idle(1); // 0x7FF -> 0xFFF
    cur_req = "R10"; bus(1, LO_A, 'h01); bus(1, LO_A, 'h80); bus(1, LO_A, 'hFE); idle(1);
    cur_req = "R5";  bus(1, LO_A, 'h12); idle(1); bus(1, LO_A, 'h34); bus(1, LO_A, 'h56); idle(2);
    cur_req = "R7";  bus(1, 'hC123, 'h99); idle(1); bus(1, LO_A, 'h00); idle(1);
    cur_req = "R7";  bus(1, 'hCFFF, 'h00); bus(1, 'hC000, 'hFF); idle(1);
    cur_req = "R8";  bus(1, NIB_A, 'h09); bus(1, LO_A, 'h5A); idle(1);
    cur_req = "R8";  bus(1, 'h0ABC, 'h00); bus(1, LO_A, 'h66); idle(2);
    cur_req = "R1";  #1 rst_n = 1'b0; idle(2); #0.5 rst_n = 1'b1; idle(2);
    cur_req = "R2";  bus(1, LO_A, 'hC3); idle(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired in %s act 0 exp 1", cur_req);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule